// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is the register core of a two-port, 16-pin general-purpose I/O expander that sits behind a byte-oriented serial slave. A bus front end decodes the serial protocol and hands the core three kinds of event: the start of a transaction, a written byte, and a request for a byte to read. The first byte written after a transaction start is a command byte. It loads a register pointer. Later written bytes store into the register that the pointer selects. Read requests return the selected register one cycle later.

The core holds three 8-bit registers for each port: an output latch, a polarity-inversion mask and a direction mask. The pin inputs are brought into the clock domain through a two-flop synchronizer. A read of an input register returns the synchronized pin level XORed with the polarity mask. Each pin drives its output-latch bit. Its output enable is the inverse of its direction bit, where 1 means input.

After each data byte is read or written, the pointer moves to the other register of the same pair. A host can therefore access both ports of one register kind in a single transaction. The pointer is kept across transactions, so a read transaction with no command byte reuses the last selection.

Top module: `gpx_core`

## Requirements
- R1: After reset, the output latches are all ones, the polarity masks are all zeros and the direction masks are all ones. As a result `pin_oe` is 0 and `pin_out` is all ones.
- R2: A byte written in the cycle `txn_start` is asserted, or as the first written byte after a `txn_start`, is a command byte. Its low 3 bits load the pointer and its upper bits are ignored. Pointer codes: 0/1 are input port 0/1, 2/3 are output port 0/1, 4/5 are polarity port 0/1, 6/7 are direction port 0/1.
- R3: A data byte (any written byte that is not a command byte) stores into the selected register. The pointer then flips its bit 0, so 0↔1, 2↔3, 4↔5 and 6↔7.
- R4: A `rd_req` without `wr_valid` in the same cycle returns the selected register on `rd_data`, with `rd_valid` high, in the next cycle. The pointer then flips its bit 0.
- R5: The pointer keeps its value across transactions. A read after a `txn_start` with no command byte uses the last pointer.
- R6: Reading pointer code 0 or 1 returns the synchronized pin level of that port XORed with its polarity mask. This holds whatever the pin's direction is.
- R7: Data bytes written to pointer codes 0 and 1 change no register, but the pointer still flips.
- R8: Reading an output register returns the latched value, not the pin level.
- R9: `pin_out[n]` equals output-latch bit n, and `pin_oe[n]` is the inverse of direction bit n. Both change only in the cycle after a data write or a reset.
- R10: A pin change that is stable before clock edge e is seen by a read captured at edge e+2, and not by reads captured at edges e or e+1.
- R11: When `rd_req` and `wr_valid` are high in the same cycle, the write is performed and the read is ignored. No `rd_valid` follows, and the read does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Start of a bus transaction; the next written byte is a command |
| wr_valid | input | 1 | Written-byte strobe |
| wr_data | input | PORT_W | Written byte |
| rd_req | input | 1 | Request for one read byte |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_req` |
| rd_data | output | PORT_W | Read byte |
| pin_in | input | 2*PORT_W | Raw pin levels, port 1 in the upper half |
| pin_out | output | 2*PORT_W | Per-pin driven value |
| pin_oe | output | 2*PORT_W | Per-pin output enable, 1 = drive |

## Verification
The bench builds the core with its default `PORT_W` of 8 and `SYNC_STAGES` of 2. With these values the eight pointer codes are the full command space, and any upper command bits test the masking of the pointer. The two-stage setting keeps the synchronizer latency short. Directed reads can then land on the exact edge where a pin change first becomes visible, and on both edges before it. The pair-toggle, write-while-read and pointer-retention cases are driven through the same eight registers, so every register kind is reached from both of its ports.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int PTR_W = 3;
  localparam int NUM_PORTS = 2;

  // pointer bits [2:1] select the register kind, bit 0 the port
  typedef enum logic [1:0] {
    KIND_IN  = 2'd0,
    KIND_OUT = 2'd1,
    KIND_INV = 2'd2,
    KIND_DIR = 2'd3
  } gpx_kind_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpx_ptr_ctrl.sv
module gpx_ptr_ctrl
  import gpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             txn_start,
  input  logic             wr_valid,
  input  logic [PTR_W-1:0] cmd_bits,
  input  logic             rd_req,
  output logic [PTR_W-1:0] ptr,
  output logic             cmd_phase,
  output logic             data_wr,
  output logic             rd_take
);
  logic cmd_pend;

  assign cmd_phase = txn_start | cmd_pend;
  assign data_wr   = wr_valid & ~cmd_phase;
  assign rd_take   = rd_req & ~wr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      cmd_pend <= 1'b1;
    end else begin
      if (wr_valid && cmd_phase) begin
        ptr      <= cmd_bits;
        cmd_pend <= 1'b0;
      end else begin
        if (data_wr || rd_take) ptr <= ptr ^ PTR_W'(1);
        if (txn_start) cmd_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int PINS  = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  sel,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PINS-1:0]   pins_sync,
  output logic              rd_valid,
  output logic [PORT_W-1:0] rd_data,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  gpx_kind_e kind;
  logic      port;
  assign kind = gpx_kind_e'(sel[2:1]);
  assign port = sel[0];

  logic [PORT_W-1:0] out_q [NUM_PORTS];
  logic [PORT_W-1:0] inv_q [NUM_PORTS];
  logic [PORT_W-1:0] oe_q  [NUM_PORTS];
  logic [PORT_W-1:0] pin_w [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_en && (port == p[0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[p] <= '1;
        inv_q[p] <= '0;
        oe_q[p]  <= '0;
      end else if (hit) begin
        case (kind)
          KIND_OUT: out_q[p] <= wr_data;
          KIND_INV: inv_q[p] <= wr_data;
          KIND_DIR: oe_q[p]  <= ~wr_data;
          default:  ;
        endcase
      end
    end

    assign pin_w[p] = pins_sync[p*PORT_W +: PORT_W];
    assign pin_out[p*PORT_W +: PORT_W] = out_q[p];
    assign pin_oe[p*PORT_W +: PORT_W]  = oe_q[p];
  end

  logic [PORT_W-1:0] rd_mux;
  always_comb begin
    case (kind)
      KIND_IN:  rd_mux = pin_w[port] ^ inv_q[port];
      KIND_OUT: rd_mux = out_q[port];
      KIND_INV: rd_mux = inv_q[port];
      default:  rd_mux = ~oe_q[port];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/gpx_core.sv
module gpx_core
  import gpx_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PINS       = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic              wr_valid,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [PORT_W-1:0] rd_data,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  logic [PTR_W-1:0] ptr;
  logic             cmd_phase;
  logic             data_wr;
  logic             rd_take;
  logic [PINS-1:0]  pins_sync;

  gpx_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_sync)
  );

  gpx_ptr_ctrl u_ptr (
    .clk       (clk),
    .rst       (rst),
    .txn_start (txn_start),
    .wr_valid  (wr_valid),
    .cmd_bits  (wr_data[PTR_W-1:0]),
    .rd_req    (rd_req),
    .ptr       (ptr),
    .cmd_phase (cmd_phase),
    .data_wr   (data_wr),
    .rd_take   (rd_take)
  );

  gpx_regfile #(.PORT_W(PORT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (data_wr),
    .rd_en     (rd_take),
    .sel       (ptr),
    .wr_data   (wr_data),
    .pins_sync (pins_sync),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk #(
  parameter int PORT_W = 8,
  localparam int PINS  = 2 * PORT_W
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_valid,
  input logic [2:0]      cmd_bits,
  input logic            rd_req,
  input logic            rd_valid,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [2:0]      ptr,
  input logic            cmd_phase
);
  assert_reset_pins_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '1));

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && cmd_phase) |=> (ptr == $past(cmd_bits)));

  assert_ptr_swap_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !cmd_phase) |=> (ptr == ($past(ptr) ^ 3'd1)));

  assert_rd_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_valid) |=> rd_valid);

  assert_pins_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_valid) && !$past(rst)) |-> ($stable(pin_out) && $stable(pin_oe)));

  assert_rd_block_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wr_valid) |=> !rd_valid);
endmodule

bind gpx_core gpx_core_chk #(.PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .cmd_bits  (wr_data[2:0]),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .ptr       (ptr),
  .cmd_phase (cmd_phase)
);

// File: tb/gpx_core_bench.sv
`timescale 1ns/1ps
module gpx_core_bench;
  localparam int PW   = 8;
  localparam int PINS = 2 * PW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            txn_start = 1'b0;
  logic            wr_valid = 1'b0;
  logic [PW-1:0]   wr_data = '0;
  logic            rd_req = 1'b0;
  logic            rd_valid;
  logic [PW-1:0]   rd_data;
  logic [PINS-1:0] pin_in = '0;
  logic [PINS-1:0] pin_out;
  logic [PINS-1:0] pin_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpx_core #(.PORT_W(PW), .SYNC_STAGES(2)) u_gpx_core (
    .clk(clk), .rst(rst), .txn_start(txn_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // behavioural reference model
  logic [PW-1:0]   m_out [2];
  logic [PW-1:0]   m_inv [2];
  logic [PW-1:0]   m_dir [2];
  logic [PINS-1:0] m_hist [$];
  int              m_ptr;
  bit              m_cmd;
  bit              m_rv;
  logic [PW-1:0]   m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        m_out[p] = '1; m_inv[p] = '0; m_dir[p] = '1;
      end
      m_hist = {};
      m_hist.push_back('0);
      m_hist.push_back('0);
      m_ptr = 0; m_cmd = 1; m_rv = 0; m_rd = '0;
    end else begin
      int prt;
      logic [PINS-1:0] seen;
      prt  = m_ptr % 2;
      seen = m_hist[0];
      m_rv = 0;
      if (wr_valid && (txn_start || m_cmd)) begin
        m_ptr = wr_data % 8;
        m_cmd = 0;
      end else begin
        if (wr_valid) begin
          case (m_ptr / 2)
            1: m_out[prt] = wr_data;
            2: m_inv[prt] = wr_data;
            3: m_dir[prt] = wr_data;
            default: ;
          endcase
          m_ptr = m_ptr ^ 1;
        end else if (rd_req) begin
          case (m_ptr / 2)
            0: m_rd = seen[prt*PW +: PW] ^ m_inv[prt];
            1: m_rd = m_out[prt];
            2: m_rd = m_inv[prt];
            default: m_rd = m_dir[prt];
          endcase
          m_rv  = 1;
          m_ptr = m_ptr ^ 1;
        end
        if (txn_start) m_cmd = 1;
      end
      void'(m_hist.pop_front());
      m_hist.push_back(pin_in);
    end
  end

  task automatic chk(input string tag, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R9 pin_out vs model", pin_out, {m_out[1], m_out[0]});
      chk("R9 pin_oe vs model", pin_oe, ~{m_dir[1], m_dir[0]});
      chk("R4 rd_valid vs model", PINS'(rd_valid), PINS'(m_rv));
      if (m_rv) chk("R4 rd_data vs model", PINS'(rd_data), PINS'(m_rd));
    end
  end

  // tasks start just after a falling edge and return just after one
  task automatic wr_byte(input logic [PW-1:0] d, input bit start);
    wr_valid = 1; wr_data = d; txn_start = start;
    @(posedge clk); @(negedge clk);
    wr_valid = 0; txn_start = 0;
  endtask

  task automatic rd_byte(input string tag, input logic [PW-1:0] exp);
    rd_req = 1;
    @(posedge clk); @(negedge clk);
    rd_req = 0;
    chk(tag, PINS'(rd_data), PINS'(exp));
  endtask

  task automatic start_only();
    txn_start = 1;
    @(posedge clk); @(negedge clk);
    txn_start = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pin_in = 16'hA53C;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pin_oe reset", pin_oe, '0);
    chk("R1 pin_out reset", pin_out, '1);
    wr_byte(8'h04, 1);
    rd_byte("R1 polarity0 reset", 8'h00);
    rd_byte("R1 polarity1 reset", 8'h00);
    wr_byte(8'h06, 1);
    rd_byte("R1 direction0 reset", 8'hFF);
    rd_byte("R1 direction1 reset", 8'hFF);

    // R3 writes with pair toggle
    wr_byte(8'h02, 1);
    wr_byte(8'h12, 0);
    wr_byte(8'h34, 0);
    chk("R3 output latches on pins", pin_out, 16'h3412);
    // R2 upper command bits ignored
    wr_byte(8'hFA, 1);
    rd_byte("R2 masked pointer read", 8'h12);
    rd_byte("R4 read toggles pointer", 8'h34);
    // R5 pointer retained (now 2)
    start_only();
    rd_byte("R5 retained pointer", 8'h12);

    // R9 direction drives output enable
    wr_byte(8'h06, 1);
    wr_byte(8'h0F, 0);
    wr_byte(8'hF0, 0);
    chk("R9 pin_oe from direction", pin_oe, 16'h0FF0);
    chk("R9 pin_out unchanged", pin_out, 16'h3412);

    // R8 output read returns latch, pins differ
    wr_byte(8'h02, 1);
    rd_byte("R8 output latch not pin", 8'h12);

    // R6 input with polarity, pins in both directions
    pin_in = 16'h5AC3;
    wr_byte(8'h04, 1);
    wr_byte(8'hFF, 0);
    wr_byte(8'h00, 0);
    wr_byte(8'h00, 1);
    rd_byte("R6 inverted input port0", 8'h3C);
    rd_byte("R6 plain input port1", 8'h5A);

    // R7 input write ignored, pointer still flips
    wr_byte(8'h00, 1);
    wr_byte(8'h77, 0);
    rd_byte("R7 pointer flipped after input write", 8'h5A);
    wr_byte(8'h00, 1);
    rd_byte("R7 input unchanged by write", 8'h3C);

    // R10 synchronizer latency
    wr_byte(8'h04, 1);
    wr_byte(8'h00, 0);
    wr_byte(8'h00, 1);
    pin_in = 16'h1122;
    rd_req = 1;
    @(posedge clk); @(negedge clk);
    chk("R10 edge e sees old", PINS'(rd_data), 16'h00C3);
    @(posedge clk); @(negedge clk);
    chk("R10 edge e+1 sees old", PINS'(rd_data), 16'h005A);
    @(posedge clk); @(negedge clk);
    rd_req = 0;
    chk("R10 edge e+2 sees new", PINS'(rd_data), 16'h0022);

    // R11 command with start in same cycle, write beats read
    wr_byte(8'h03, 1);
    rd_byte("R11 same-cycle command byte", 8'h34);
    wr_byte(8'h02, 1);
    wr_valid = 1; wr_data = 8'h99; rd_req = 1;
    @(posedge clk); @(negedge clk);
    wr_valid = 0; rd_req = 0;
    chk("R11 no rd_valid on collision", PINS'(rd_valid), '0);
    chk("R11 write performed", pin_out, 16'h3499);
    rd_byte("R11 read did not move pointer", 8'h34);

    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule